// File: doc/BRIEF.md
# PS/2 Host Port with Register Interface

This block connects a keyboard or mouse to a chip over the two-wire PS/2 link. The clock and data lines are open-drain. The block samples both lines through synchronisers, and it pulls a line low only through one "drive low" output per wire. Frames that the device sends are checked and stored in a receive queue. Bytes that software writes are held in a transmit queue and sent with the host request-to-send handshake.

Software sees four 32-bit registers on a simple read/write port.

| Byte offset | Register |
|---|---|
| 0x0 | data |
| 0x4 | status |
| 0x8 | control |
| 0xC | timer reload |

Reading data pops the next received byte. Writing data queues a byte for sending. Status shows the queue levels, the sticky error flags and whether the host is holding the clock. The reload value sets the length of the host inhibit period. Software normally programs it so that one period lasts 100 µs.

There is one interrupt output. It combines a level that stays high while received data is waiting with a one-cycle pulse when the transmit queue runs dry.

Top module: `ps2_host_port`

## Requirements
- R1: After reset, status and control read 0, reload reads its reset parameter (default 5000), the interrupt is low, and neither line is driven low. Registers are decoded at byte offsets data 0x0, status 0x4, control 0x8 and reload 0xC.
- R2: Device frames are sampled on falling edges of the synchronised clock. A frame is a start bit of 0, eight data bits LSB first, an odd-parity bit and a stop bit of 1, and a good frame stores its byte. A falling edge seen while idle with data high does not start a frame.
- R3: A frame whose parity bit does not give odd parity over data plus parity sets status bit 1, and its byte is discarded.
- R4: A frame with a stop bit of 0 sets status bit 2 and is discarded. A transmitted frame whose acknowledge bit (data sampled on the 11th device falling edge) is high also sets status bit 2.
- R5: Writing the value 0 to status clears bits 1 and 2. Writing any other value to status changes nothing.
- R6: Reading data returns the oldest byte in bits 7:0 and removes it. Status bit 0 is high while the receive queue holds data, bits 31:27 give its fill count, and bit 4 shows it full at 16 entries. A byte that completes while the queue is full is dropped.
- R7: While control bit 0 (receive enable) is 0, device frames are ignored.
- R8: Writing data queues bits 7:0 only if the transmit queue is not full. Status bits 26:22 give its count and bit 5 shows it full at 16 entries.
- R9: A transmission starts by holding clock low for exactly reload+1 cycles, with status bit 3 high during that time. The host then releases clock and pulls data low, and it never drives both lines low at once.
- R10: After the request, the host presents eight data bits LSB first, then odd parity, then a released stop bit, changing data after each device falling edge.
- R11: The interrupt is high whenever control bits 0 and 2 are both set and the receive queue is not empty.
- R12: With control bit 3 set, the interrupt pulses for exactly one cycle when a frame start takes the last byte from the transmit queue.
- R13: No transmission starts while control bit 1 (transmit enable) is 0. Queued bytes wait until it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data offset) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| ps2_clk_in | input | 1 | Sensed level of the PS/2 clock wire |
| ps2_dat_in | input | 1 | Sensed level of the PS/2 data wire |
| ps2_clk_low | output | 1 | Pull the clock wire low |
| ps2_dat_low | output | 1 | Pull the data wire low |
| irq | output | 1 | Combined interrupt |

## Verification
A receive shifter that is out of step corrupts or drops the very next frame, and this shows in the read byte or in the error flags within one frame time. A wrong queue pointer or count shows up on the next data read or status read, and as a lasting or missing interrupt level on the following cycle. A fault in the transmit sequencer shows up at the line outputs within one frame. It appears as an inhibit of the wrong length, a wrong bit seen on a device rising edge, or a missing release, and the device model captures each of these bit by bit.

// File: rtl/ps2_host_pkg.sv
// Shared constants and types for the PS/2 host port.
// Assumes the register port decodes byte offsets on a 4-bit address.
package ps2_host_pkg;

    localparam logic [3:0] OFS_DATA   = 4'h0;
    localparam logic [3:0] OFS_STAT   = 4'h4;
    localparam logic [3:0] OFS_CTRL   = 4'h8;
    localparam logic [3:0] OFS_RELOAD = 4'hC;

    // Control register, packed so that bit 0 is rx_en.
    typedef struct packed {
        logic tx_irq_en;
        logic rx_irq_en;
        logic tx_en;
        logic rx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_INHIBIT,
        TX_SEND
    } tx_state_t;

    // Bit that makes data plus parity hold an odd number of ones.
    function automatic logic odd_par(input logic [7:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/ps2_line_sync.sv
// Synchroniser and falling-edge detector for one PS/2 wire.
// Assumes the wire idles high. STAGES >= 2.
module ps2_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw wire through the flop chain and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = prev & ~chain[STAGES-1];
endmodule

// File: rtl/ps2_fifo.sv
// Show-ahead FIFO: rdata presents the oldest entry.
// A push while full is dropped, and a pop while empty is ignored.
module ps2_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Store accepted writes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Advance pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ps2_rx.sv
// Receive deserialiser for device-to-host frames.
// Works on synchronised falling edges. The frame is a start bit of 0, 8 data
// bits LSB first, odd parity and a stop bit of 1. Bad frames raise an error
// pulse and are not delivered. Clearing enable abandons a partial frame.
module ps2_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       fall,
    input  logic       dat,
    output logic       busy,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       par_err,
    output logic       frm_err
);
    import ps2_host_pkg::*;

    logic [3:0] bit_cnt;
    logic [8:0] shreg;
    logic [9:0] frame;
    logic       par_ok;

    assign frame  = {dat, shreg};
    assign par_ok = ^frame[8:0];
    assign busy   = (bit_cnt != 4'd0);

    // Frame sequencer: count bits, shift, and judge the frame at the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= 4'd0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            par_err    <= 1'b0;
            frm_err    <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            par_err    <= 1'b0;
            frm_err    <= 1'b0;
            if (!enable) begin
                bit_cnt <= 4'd0;
            end else if (fall) begin
                if (bit_cnt == 4'd0) begin
                    if (!dat) bit_cnt <= 4'd1;
                end else if (bit_cnt == 4'd10) begin
                    bit_cnt    <= 4'd0;
                    byte_data  <= frame[7:0];
                    byte_valid <= par_ok & frame[9];
                    par_err    <= ~par_ok;
                    frm_err    <= ~frame[9];
                end else begin
                    shreg   <= {dat, shreg[8:1]};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_tx.sv
// Host-to-device sender with its own inhibit timer.
// Holds clock low for reload+1 cycles, then requests with data low and shifts
// d0..d7, parity and stop on device falling edges. It samples the acknowledge
// bit on the 11th edge. Assumes reload >= 4 so that the edge the host itself
// causes has passed the synchroniser before the request phase.
module ps2_tx #(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                have_data,
    input  logic                rx_busy,
    input  logic [7:0]          tx_byte,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                fall,
    input  logic                dat,
    output logic                take,
    output logic                idle,
    output logic                inhibit,
    output logic                clk_low,
    output logic                dat_low,
    output logic                nack
);
    import ps2_host_pkg::*;

    tx_state_t           state;
    logic [RELOAD_W-1:0] timer;
    logic [3:0]          bit_cnt;
    logic [8:0]          shreg;
    logic                bit_out;

    assign idle    = (state == TX_IDLE);
    assign inhibit = (state == TX_INHIBIT);
    assign take    = idle & enable & have_data & ~rx_busy;
    assign clk_low = inhibit;
    assign dat_low = (state == TX_SEND) & ~bit_out;

    // Sequencer covering the inhibit timer, request, bit shifting and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            timer   <= '0;
            bit_cnt <= 4'd0;
            shreg   <= '0;
            bit_out <= 1'b1;
            nack    <= 1'b0;
        end else begin
            nack <= 1'b0;
            unique case (state)
                TX_IDLE: begin
                    if (take) begin
                        shreg <= {odd_par(tx_byte), tx_byte};
                        timer <= reload;
                        state <= TX_INHIBIT;
                    end
                end
                TX_INHIBIT: begin
                    if (timer == '0) begin
                        bit_out <= 1'b0;
                        bit_cnt <= 4'd0;
                        state   <= TX_SEND;
                    end else begin
                        timer <= timer - RELOAD_W'(1);
                    end
                end
                TX_SEND: begin
                    if (fall) begin
                        if (bit_cnt == 4'd10) begin
                            nack    <= dat;
                            bit_out <= 1'b1;
                            state   <= TX_IDLE;
                        end else begin
                            bit_out <= shreg[0];
                            shreg   <= {1'b1, shreg[8:1]};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_host_port.sv
// PS/2 host port: register file, receive and transmit queues, and line engines.
// Assumes a single-cycle register port. reg_rdata is combinational in the
// cycle of reg_rd, and a read of the data offset pops on that clock edge.
module ps2_host_port #(
    parameter int                FIFO_DEPTH = 16,
    parameter int                SYNC_STAGES = 2,
    parameter int                RELOAD_W   = 16,
    parameter logic [RELOAD_W-1:0] RELOAD_RST = RELOAD_W'(5000),
    localparam int               CW         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ps2_clk_in,
    input  logic        ps2_dat_in,
    output logic        ps2_clk_low,
    output logic        ps2_dat_low,
    output logic        irq
);
    import ps2_host_pkg::*;

    ctrl_t               ctrl;
    logic [RELOAD_W-1:0] reload;
    logic                err_pe, err_fe, tx_irq_q;

    logic                clk_lvl, clk_fall, dat_lvl, dat_fall;
    logic                rx_busy, rx_valid, rx_pe, rx_fe;
    logic [7:0]          rx_byte, rx_head, tx_head;
    logic                rx_push, rx_pop, tx_push, tx_pop;
    logic [CW-1:0]       rx_cnt, tx_cnt;
    logic                rx_full, rx_empty, tx_full, tx_empty;
    logic                tx_idle, tx_inhibit, tx_nack;
    logic                stat_clr;
    logic [31:0]         stat_word;

    // Clock and data synchronisers, one per wire.
    ps2_line_sync #(.STAGES(SYNC_STAGES)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .line_in(ps2_clk_in),
        .level(clk_lvl), .fall(clk_fall));
    ps2_line_sync #(.STAGES(SYNC_STAGES)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .line_in(ps2_dat_in),
        .level(dat_lvl), .fall(dat_fall));

    ps2_rx u_rx (
        .clk(clk), .rst_n(rst_n), .enable(ctrl.rx_en & tx_idle),
        .fall(clk_fall), .dat(dat_lvl), .busy(rx_busy),
        .byte_valid(rx_valid), .byte_data(rx_byte),
        .par_err(rx_pe), .frm_err(rx_fe));

    assign rx_push = rx_valid;
    assign rx_pop  = reg_rd & (reg_addr == OFS_DATA);

    ps2_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty));

    assign tx_push = reg_wr & (reg_addr == OFS_DATA);

    ps2_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(reg_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));

    ps2_tx #(.RELOAD_W(RELOAD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable(ctrl.tx_en), .have_data(~tx_empty),
        .rx_busy(rx_busy), .tx_byte(tx_head), .reload(reload),
        .fall(clk_fall), .dat(dat_lvl), .take(tx_pop), .idle(tx_idle),
        .inhibit(tx_inhibit), .clk_low(ps2_clk_low), .dat_low(ps2_dat_low),
        .nack(tx_nack));

    assign stat_clr = reg_wr & (reg_addr == OFS_STAT) & (reg_wdata == 32'd0);

    // Control and reload registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            reload <= RELOAD_RST;
        end else if (reg_wr) begin
            if (reg_addr == OFS_CTRL)   ctrl   <= ctrl_t'(reg_wdata[3:0]);
            if (reg_addr == OFS_RELOAD) reload <= reg_wdata[RELOAD_W-1:0];
        end
    end

    // Sticky error flags: a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pe <= 1'b0;
            err_fe <= 1'b0;
        end else begin
            err_pe <= rx_pe | (err_pe & ~stat_clr);
            err_fe <= rx_fe | tx_nack | (err_fe & ~stat_clr);
        end
    end

    // One-cycle pulse when a frame start empties the transmit queue.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq_q <= 1'b0;
        else        tx_irq_q <= ctrl.tx_irq_en & tx_pop & ~tx_push &
                                (tx_cnt == CW'(1));
    end

    assign stat_word = {5'(rx_cnt), 5'(tx_cnt), 16'd0, tx_full, rx_full,
                        tx_inhibit, err_fe, err_pe, ~rx_empty};

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr)
            OFS_DATA:   reg_rdata = {24'd0, rx_head};
            OFS_STAT:   reg_rdata = stat_word;
            OFS_CTRL:   reg_rdata = {28'd0, ctrl};
            OFS_RELOAD: reg_rdata = 32'(reload);
            default:    reg_rdata = 32'd0;
        endcase
    end

    assign irq = (ctrl.rx_en & ctrl.rx_irq_en & ~rx_empty) | tx_irq_q;

endmodule

// File: rtl/ps2_host_port_chk.sv
// Property checker for ps2_host_port, attached with bind.
module ps2_host_port_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_low,
    input logic          dat_low,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic          rx_full,
    input logic          tx_full,
    input logic          rx_push,
    input logic          rx_pop,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          tx_irq,
    input logic          stat_clr,
    input logic          new_err,
    input logic          err_pe,
    input logic          err_fe
);
    p_lines_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_low && dat_low));

    p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    p_rx_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && rx_push && !rx_pop) |=> $stable(rx_cnt));

    p_tx_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && tx_push && !tx_pop) |=> $stable(tx_cnt));

    p_tx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !new_err) |=> (!err_pe && !err_fe));
endmodule

bind ps2_host_port ps2_host_port_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_low(ps2_clk_low), .dat_low(ps2_dat_low),
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_full(rx_full), .tx_full(tx_full),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .tx_irq(tx_irq_q), .stat_clr(stat_clr),
    .new_err(rx_pe | rx_fe | tx_nack), .err_pe(err_pe), .err_fe(err_fe));

// File: tb/ps2_host_port_tb_top.sv
// Bench: a device model on open-drain wires, a queue-based reference model of
// the receive side, and a per-clock comparison of irq and the line drives.
module ps2_host_port_tb_top;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_clk_low, host_dat_low, irq;
    logic        dev_clk_low = 1'b0, dev_dat_low = 1'b0;
    wire         clk_line = ~(host_clk_low | dev_clk_low);
    wire         dat_line = ~(host_dat_low | dev_dat_low);

    int total = 0, fails = 0, irq_hi = 0;
    bit cmp_en = 1'b0, done = 1'b0;

    // Reference model state
    logic [7:0] m_q[$];
    bit m_pe = 0, m_fe = 0, m_re = 0, m_ri = 0;

    always #5 clk = ~clk;

    ps2_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
        .ps2_clk_low(host_clk_low), .ps2_dat_low(host_dat_low), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Per-clock comparison against the model (R11 level, R1 released lines).
    initial forever begin
        @(posedge clk); #2;
        if (cmp_en && rst_n) begin
            chk("R11 irq level", {31'd0, irq}, {31'd0, m_re & m_ri & (m_q.size() != 0)});
            chk("R1 lines released", {30'd0, host_clk_low, host_dat_low}, 32'd0);
        end
    end

    always @(negedge clk) if (irq) irq_hi++;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        if (a == 4'h8) begin m_re = d[0]; m_ri = d[2]; end
        if (a == 4'h4 && d == 0) begin m_pe = 0; m_fe = 0; end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        if (a == 4'h0 && m_q.size() != 0) void'(m_q.pop_front());
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat(input int tcnt, input bit ki);
        return {5'(m_q.size()), 5'(tcnt), 16'd0, tcnt == 16, m_q.size() == 16,
                ki, m_fe, m_pe, m_q.size() != 0};
    endfunction

    // Device sends one frame; the model is updated per the requirements.
    task automatic dev_send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        logic [10:0] bits;
        cmp_en = 0;
        bits = {~bad_stop, (~^d) ^ bad_par, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            dev_dat_low = ~bits[i];
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b0;
            repeat (H) @(negedge clk);
        end
        dev_dat_low = 1'b0;
        if (m_re) begin
            if (!bad_par && !bad_stop && m_q.size() < 16) m_q.push_back(d);
            if (bad_par) m_pe = 1;
            if (bad_stop) m_fe = 1;
        end
        cmp_en = 1;
    endtask

    // Device receives one host frame: reports byte, parity, stop, inhibit length.
    task automatic dev_recv(input bit ack, output logic [9:0] got,
                            output int inh_len, output bit req_ok);
        cmp_en = 0;
        while (!host_clk_low) @(negedge clk);
        inh_len = 0;
        while (host_clk_low) begin inh_len++; @(negedge clk); end
        req_ok = host_dat_low;
        for (int k = 1; k <= 11; k++) begin
            if (k == 11 && ack) dev_dat_low = 1'b1;
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b1;
            repeat (H) @(negedge clk);
            dev_clk_low = 1'b0;
            repeat (H) @(negedge clk);
            if (k <= 10) got[k-1] = dat_line;
        end
        dev_dat_low = 1'b0;
    endtask

    initial begin
        logic [31:0] rd;
        logic [9:0]  got;
        int          ilen;
        bit          rq;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;

        // R1: reset state
        bus_read(4'h4, rd); chk("R1 status reset", rd, 32'd0);
        bus_read(4'h8, rd); chk("R1 control reset", rd, 32'd0);
        bus_read(4'hC, rd); chk("R1 reload reset", rd, 32'd5000);
        chk("R1 irq reset", {31'd0, irq}, 32'd0);

        // R2, R11, R6: good frames, interrupt level, in-order reads
        bus_write(4'h8, 32'h5);
        dev_send(8'hA5, 0, 0);
        chk("R11 irq with data", {31'd0, irq}, 32'd1);
        bus_read(4'h4, rd); chk("R6 status one byte", rd, exp_stat(0, 0));
        bus_read(4'h0, rd); chk("R2 byte A5", rd, 32'hA5);
        dev_send(8'h3C, 0, 0);
        dev_send(8'h01, 0, 0);
        bus_read(4'h4, rd); chk("R6 count two", rd, exp_stat(0, 0));
        bus_read(4'h0, rd); chk("R6 first of two", rd, 32'h3C);
        bus_read(4'h0, rd); chk("R6 second of two", rd, 32'h01);
        chk("R11 irq drained", {31'd0, irq}, 32'd0);

        // R2: lone falling edge with data high does not start a frame
        cmp_en = 0;
        dev_clk_low = 1'b1; repeat (H) @(negedge clk);
        dev_clk_low = 1'b0; repeat (H) @(negedge clk);
        cmp_en = 1;
        dev_send(8'h5A, 0, 0);
        bus_read(4'h0, rd); chk("R2 after glitch", rd, 32'h5A);

        // R3: parity error, byte discarded
        dev_send(8'h77, 1, 0);
        bus_read(4'h4, rd); chk("R3 parity flag", rd, exp_stat(0, 0));
        chk("R3 parity bit1", {31'd0, rd[1]}, 32'd1);

        // R5: nonzero write keeps flags, zero clears
        bus_write(4'h4, 32'h6);
        bus_read(4'h4, rd); chk("R5 nonzero write ignored", {30'd0, rd[2:1]}, 32'd1);
        bus_write(4'h4, 32'h0);
        bus_read(4'h4, rd); chk("R5 zero write clears", rd, 32'd0);

        // R4: stop bit 0
        dev_send(8'h2E, 0, 1);
        bus_read(4'h4, rd); chk("R4 framing flag", rd, exp_stat(0, 0));
        chk("R4 framing bit2", {31'd0, rd[2]}, 32'd1);
        bus_write(4'h4, 32'h0);

        // R7: receive disabled
        bus_write(4'h8, 32'h4);
        dev_send(8'h11, 0, 0);
        bus_read(4'h4, rd); chk("R7 frame ignored", rd, 32'd0);

        // R6: fill to 16, 17th dropped
        bus_write(4'h8, 32'h5);
        for (int i = 0; i < 17; i++) dev_send(8'(8'h40 + i), 0, 0);
        bus_read(4'h4, rd); chk("R6 full status", rd, exp_stat(0, 0));
        chk("R6 full bit4 count16", {rd[31:27], rd[4]}, {5'd16, 1'b1});
        for (int i = 0; i < 16; i++) begin
            bus_read(4'h0, rd); chk("R6 drain order", rd, 32'(8'h40 + i));
        end
        bus_read(4'h4, rd); chk("R6 17th dropped", rd, 32'd0);

        // R8, R13: queue a byte while transmit disabled
        bus_write(4'h8, 32'h0);
        bus_write(4'hC, 32'd20);
        bus_write(4'h0, 32'hC3);
        bus_read(4'h4, rd); chk("R8 tx count one", rd, exp_stat(1, 0));
        repeat (100) @(negedge clk);
        chk("R13 no start without enable", {30'd0, host_clk_low, host_dat_low}, 32'd0);

        // R9, R10, R12: transmit with interrupt
        bus_write(4'h8, 32'hA);
        irq_hi = 0;
        dev_recv(1, got, ilen, rq);
        chk("R9 inhibit length", 32'(ilen), 32'd21);
        chk("R9 request data low", {31'd0, rq}, 32'd1);
        chk("R10 data bits", {24'd0, got[7:0]}, 32'hC3);
        chk("R10 parity and stop", {30'd0, got[9:8]}, {30'd0, 1'b1, ~^8'hC3});
        chk("R12 one pulse", 32'(irq_hi), 32'd1);
        cmp_en = 1;
        bus_read(4'h4, rd); chk("R4 ack ok no flag", rd, 32'd0);

        // R9: status bit 3 during inhibit
        bus_write(4'hC, 32'd40);
        bus_write(4'h0, 32'h96);
        cmp_en = 0;
        rd = 0;
        for (int i = 0; i < 8 && !rd[3]; i++) bus_read(4'h4, rd);
        chk("R9 inhibit flag", rd, exp_stat(0, 1));
        dev_recv(1, got, ilen, rq);
        chk("R10 byte 96", {24'd0, got[7:0]}, 32'h96);

        // R4: missing acknowledge
        bus_write(4'h0, 32'h42);
        dev_recv(0, got, ilen, rq);
        m_fe = 1;
        cmp_en = 1;
        bus_read(4'h4, rd); chk("R4 missing ack", rd, exp_stat(0, 0));
        bus_write(4'h4, 32'h0);

        // R8: transmit queue full, 17th write dropped
        bus_write(4'h8, 32'h0);
        for (int i = 0; i < 17; i++) bus_write(4'h0, 32'(8'h80 + i));
        bus_read(4'h4, rd); chk("R8 tx full", rd, exp_stat(16, 0));
        bus_write(4'h8, 32'h2);
        for (int i = 0; i < 16; i++) begin
            dev_recv(1, got, ilen, rq);
            chk("R10 burst byte", {24'd0, got[7:0]}, 32'(8'h80 + i));
        end
        cmp_en = 1;
        repeat (200) @(negedge clk);
        chk("R8 17th not sent", {30'd0, host_clk_low, host_dat_low}, 32'd0);
        bus_read(4'h4, rd); chk("R8 tx empty", rd, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule